// File: doc/BRIEF.md
# Eight-Bit-Parallel Recursive Convolutional Encoder

This block is the constituent encoder of a parallel-concatenated turbo code. Every clock it can take a group of eight information bits and return eight systematic bits with their eight parity bits. A 3-bit recursive state, kept in registers, links one group to the next. A code block starts with a one-cycle `start` pulse that carries the number of eight-bit groups. The block length K is eight times that number, so there is never a partial group.

The recursion is unrolled eight trellis steps deep, so one clock does eight steps. When the last group has been accepted, the block does not flush the register over three serial cycles. It spends a single tail cycle reading a small lookup addressed by the final state. That lookup gives three systematic tail bits and three parity tail bits, which together return the state to zero.

A controller with three states runs the block. IDLE waits for `start`. A start with a nonzero group count takes the transition load to DATA. A start with a zero group count takes the transition load-empty straight to TAIL. DATA accepts groups. The transition last-group moves to TAIL when the final group is accepted. TAIL presents the termination and takes the transition finish back to IDLE.

Top module: `pconv_encoder8`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready`, `out_valid` and `out_tail` are low and both output buses are zero.
- R2: A `start` pulse in IDLE with `grp_count` = G clears the trellis state to 000. If G > 0, `in_ready` is high from the next cycle until G groups have been accepted.
- R3: A group is accepted on a clock edge where `in_valid` and `in_ready` are both high. In the next cycle `out_valid` is high and `out_sys` equals the accepted `in_data`. Bit 0 is the earliest bit in time.
- R4: Each `out_par` bit follows the serial recursion over the bits in time order. The state is (M1,M2,M3), with M1 the newest. The feedback is f = u xor M2 xor M3. The parity is f xor M1 xor M3. The new state is (f, M1, M2). The state carries across groups within a block.
- R5: A DATA cycle without `in_valid` leaves the state unchanged. In the next cycle `out_valid` is low and both buses are zero.
- R6: After the G-th accept, `in_ready` is low. In the cycle after the last data output, `out_tail` is high for exactly one cycle with `out_valid` low. The block is then idle.
- R7: The tail bits sit in bits 2..0, with bit 0 earliest; the upper bits are zero. The mapping from final state M1M2M3 is written in time order as systematic bits then parity bits: 000→000,000; 001→100,100; 010→110,010; 011→010,110; 100→011,101; 101→111,001; 110→101,111; 111→001,011.
- R8: A `start` pulse outside IDLE is ignored. This includes a pulse in the same cycle as the last group's accept. The running block and its tail are unchanged, and no new block begins.
- R9: A `start` with `grp_count` = 0 gives a single all-zero tail cycle, two cycles after the pulse, and no data output.
- R10: When neither `out_valid` nor `out_tail` is high, both output buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Block start pulse, taken only in IDLE |
| grp_count | input | 12 | Number of eight-bit groups in the block |
| in_valid | input | 1 | Input group valid |
| in_ready | output | 1 | Encoder can take a group |
| in_data | input | 8 | Information bits, bit 0 earliest |
| out_valid | output | 1 | Data output valid |
| out_tail | output | 1 | Tail output valid |
| out_sys | output | 8 | Systematic bits or systematic tail |
| out_par | output | 8 | Parity bits or parity tail |

## Verification
The case that needs care is a new `start` pulse arriving in the same clock as the acceptance of a block's final group. This is the edge where the last-group transition fires, so a careless controller could reload the state or restart the count there. The bench provokes this by raising `start` with a new nonzero group count together with the last `in_valid`. It also raises `start` once in the middle of a block. It then judges the result against a bit-serial reference. The remaining data, the six tail bits and the single tail cycle must be exactly those of the uninterrupted block, and afterwards `in_ready` must stay low with no further output.

// File: rtl/pconv_pkg.sv
package pconv_pkg;

    localparam int TRELLIS_W = 3;

    typedef logic [TRELLIS_W-1:0] trellis_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_TAIL = 2'd2
    } enc_state_e;

endpackage

// File: rtl/pconv_step.sv
// One trellis step: state bit 2 is the newest register (M1), bit 0 the oldest.
module pconv_step
    import pconv_pkg::*;
(
    input  logic     u,
    input  trellis_t s_cur,
    output trellis_t s_nxt,
    output logic     par
);
    logic fb;

    always_comb begin
        fb    = u ^ s_cur[1] ^ s_cur[0];
        par   = fb ^ s_cur[2] ^ s_cur[0];
        s_nxt = {fb, s_cur[2], s_cur[1]};
    end
endmodule

// File: rtl/pconv_unroll.sv
// PAR chained trellis steps; synthesis flattens the chain into shared XOR terms.
module pconv_unroll
    import pconv_pkg::*;
#(
    parameter int PAR = 8
) (
    input  trellis_t       s_in,
    input  logic [PAR-1:0] bits,
    output logic [PAR-1:0] pars,
    output trellis_t       s_out
);
    trellis_t chain [PAR+1];

    assign chain[0] = s_in;

    for (genvar i = 0; i < PAR; i++) begin : g_step
        pconv_step u_step (
            .u     (bits[i]),
            .s_cur (chain[i]),
            .s_nxt (chain[i+1]),
            .par   (pars[i])
        );
    end

    assign s_out = chain[PAR];
endmodule

// File: rtl/pconv_tail_rom.sv
// State-addressed termination lookup. Entries are written earliest bit first.
module pconv_tail_rom
    import pconv_pkg::*;
(
    input  trellis_t   addr,
    output logic [2:0] t_sys,
    output logic [2:0] t_par
);
    logic [5:0] entry;

    always_comb begin
        unique case (addr)
            3'b000: entry = 6'b000_000;
            3'b001: entry = 6'b100_100;
            3'b010: entry = 6'b110_010;
            3'b011: entry = 6'b010_110;
            3'b100: entry = 6'b011_101;
            3'b101: entry = 6'b111_001;
            3'b110: entry = 6'b101_111;
            default: entry = 6'b001_011;
        endcase
        for (int j = 0; j < 3; j++) begin
            t_sys[j] = entry[5-j];
            t_par[j] = entry[2-j];
        end
    end
endmodule

// File: rtl/pconv_encoder8.sv
module pconv_encoder8
    import pconv_pkg::*;
#(
    parameter int PAR  = 8,
    parameter int GRPW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [GRPW-1:0] grp_count,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [PAR-1:0]  in_data,
    output logic            out_valid,
    output logic            out_tail,
    output logic [PAR-1:0]  out_sys,
    output logic [PAR-1:0]  out_par
);
    localparam int PADW = PAR - 3;

    enc_state_e      st, st_nx;
    logic [GRPW-1:0] grp_left, grp_nx;
    trellis_t        trel, trel_nx, trel_end;
    logic [PAR-1:0]  par_bits;
    logic [2:0]      t_sys, t_par;
    logic            take;

    pconv_unroll #(.PAR(PAR)) u_unroll (
        .s_in  (trel),
        .bits  (in_data),
        .pars  (par_bits),
        .s_out (trel_end)
    );

    pconv_tail_rom u_tail (
        .addr  (trel),
        .t_sys (t_sys),
        .t_par (t_par)
    );

    assign in_ready = (st == ST_DATA);
    assign take     = in_valid && in_ready;

    always_comb begin
        st_nx   = st;
        grp_nx  = grp_left;
        trel_nx = trel;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    trel_nx = '0;
                    grp_nx  = grp_count;
                    st_nx   = (grp_count == '0) ? ST_TAIL : ST_DATA;
                end
            end
            ST_DATA: begin
                if (take) begin
                    trel_nx = trel_end;
                    grp_nx  = grp_left - 1'b1;
                    if (grp_left == GRPW'(1)) st_nx = ST_TAIL;
                end
            end
            ST_TAIL: begin
                trel_nx = '0;
                st_nx   = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            grp_left <= '0;
            trel     <= '0;
        end else begin
            st       <= st_nx;
            grp_left <= grp_nx;
            trel     <= trel_nx;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tail  <= 1'b0;
            out_sys   <= '0;
            out_par   <= '0;
        end else begin
            out_valid <= take;
            out_tail  <= (st == ST_TAIL);
            if (take) begin
                out_sys <= in_data;
                out_par <= par_bits;
            end else if (st == ST_TAIL) begin
                out_sys <= {{PADW{1'b0}}, t_sys};
                out_par <= {{PADW{1'b0}}, t_par};
            end else begin
                out_sys <= '0;
                out_par <= '0;
            end
        end
    end
endmodule

// File: rtl/pconv_encoder8_chk.sv
module pconv_encoder8_chk #(
    parameter int PAR = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic [PAR-1:0] in_data,
    input logic           out_valid,
    input logic           out_tail,
    input logic [PAR-1:0] out_sys,
    input logic [PAR-1:0] out_par
);
    a_r3_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r3_sys_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_sys == $past(in_data)));

    a_r5_no_accept_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);

    a_r6_tail_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_tail |=> !out_tail);

    a_r6_tail_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        out_tail |-> !$past(in_ready));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_tail));

    a_r10_quiet_buses: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !out_tail) |-> (out_sys == '0 && out_par == '0));
endmodule

bind pconv_encoder8 pconv_encoder8_chk #(.PAR(PAR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_tail  (out_tail),
    .out_sys   (out_sys),
    .out_par   (out_par)
);

// File: tb/pconv_encoder8_bench.sv
`timescale 1ns/1ps
module pconv_encoder8_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] grp_count = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        out_valid, out_tail;
    logic [7:0]  out_sys, out_par;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pconv_encoder8 u_pconv_encoder8 (
        .clk(clk), .rst_n(rst_n), .start(start), .grp_count(grp_count),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_tail(out_tail),
        .out_sys(out_sys), .out_par(out_par)
    );

    // bit-serial reference state: r1 newest
    logic r1, r2, r3;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ref_group(input logic [7:0] d, output logic [7:0] p);
        for (int i = 0; i < 8; i++) begin
            logic f;
            f    = d[i] ^ r2 ^ r3;
            p[i] = f ^ r1 ^ r3;
            r3 = r2; r2 = r1; r1 = f;
        end
    endtask

    task automatic ref_tail(output logic [7:0] ts, output logic [7:0] tp);
        ts = '0; tp = '0;
        for (int i = 0; i < 3; i++) begin
            ts[i] = r2 ^ r3;
            tp[i] = r1 ^ r3;
            r3 = r2; r2 = r1; r1 = 1'b0;
        end
    endtask

    // generic block runner; caller scenarios pick the pattern
    task automatic run_block(input int ngr, input int gap_every,
                             input bit start_mid, input bit start_last);
        logic [7:0] d, ep, ts, tp;
        r1 = 0; r2 = 0; r3 = 0;
        @(negedge clk);
        start = 1'b1; grp_count = 12'(ngr);
        @(negedge clk);
        start = 1'b0;
        if (ngr > 0) chk(in_ready == 1'b1, "R2 ready after start", in_ready, 1);
        for (int g = 0; g < ngr; g++) begin
            if (gap_every > 0 && (g % gap_every) == 1) begin
                in_valid = 1'b0;
                @(negedge clk);
                chk(out_valid == 1'b0 && out_sys == 0 && out_par == 0,
                    "R5 gap cycle quiet", {out_valid, out_sys, out_par}, 0);
            end
            d = 8'($urandom);
            in_valid = 1'b1; in_data = d;
            if (start_mid && g == ngr / 2) begin start = 1'b1; grp_count = 12'd1; end
            if (start_last && g == ngr - 1) begin start = 1'b1; grp_count = 12'd2; end
            ref_group(d, ep);
            @(negedge clk);
            start = 1'b0; in_valid = 1'b0;
            chk(out_valid == 1'b1, "R3 out_valid after accept", out_valid, 1);
            chk(out_sys == d, "R3 systematic echo", out_sys, d);
            chk(out_par == ep, "R4 parity", out_par, ep);
        end
        chk(in_ready == 1'b0, "R6 ready low in tail cycle", in_ready, 0);
        ref_tail(ts, tp);
        @(negedge clk);
        chk(out_tail == 1'b1 && out_valid == 1'b0, "R6 tail strobe",
            {out_tail, out_valid}, 2'b10);
        chk(out_sys == ts, "R7 systematic tail", out_sys, ts);
        chk(out_par == tp, "R7 parity tail", out_par, tp);
        @(negedge clk);
        chk(out_tail == 1'b0 && in_ready == 1'b0, "R8 idle after tail, no restart",
            {out_tail, in_ready}, 0);
        @(negedge clk);
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R8 still idle",
            {in_ready, out_valid}, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(in_ready == 0 && out_valid == 0 && out_tail == 0, "R1 control in reset",
            {in_ready, out_valid, out_tail}, 0);
        chk(out_sys == 0 && out_par == 0, "R1 buses in reset", {out_sys, out_par}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 0 && out_valid == 0 && out_tail == 0, "R1 first cycle after reset",
            {in_ready, out_valid, out_tail}, 0);
    endtask

    task automatic t_single_group();   // R3 R4 R6 R7
        run_block(1, 0, 0, 0);
    endtask

    task automatic t_long_with_gaps(); // R4 R5 across groups
        run_block(9, 3, 0, 0);
    endtask

    task automatic t_back_to_back();   // R2 state cleared per block
        run_block(4, 0, 0, 0);
        run_block(5, 2, 0, 0);
    endtask

    task automatic t_start_overlap();  // R8 start mid-block and at last accept
        run_block(6, 0, 1, 1);
    endtask

    task automatic t_zero_len();       // R9
        @(negedge clk);
        start = 1'b1; grp_count = 12'd0;
        @(negedge clk);
        start = 1'b0;
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R9 no data phase",
            {in_ready, out_valid}, 0);
        @(negedge clk);
        chk(out_tail == 1'b1 && out_sys == 0 && out_par == 0, "R9 all-zero tail",
            {out_tail, out_sys, out_par}, 17'h10000);
        @(negedge clk);
        chk(out_tail == 1'b0, "R9 tail single cycle", out_tail, 0);
    endtask

    task automatic t_many_tails();     // R7 across final states
        for (int n = 0; n < 40; n++) run_block(1 + (n % 3), 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        t_reset();
        t_single_group();
        t_long_with_gaps();
        t_back_to_back();
        t_start_overlap();
        t_zero_len();
        t_many_tails();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule